// File: doc/BRIEF.md
# One-Wire Bus Master Engine

This block is the timing engine for a single open-drain one-wire line. It turns three kinds of command into waveforms on that line: a bus reset with detection of a device's presence answer, the transmission of one byte, and the reception of one byte. It counts every window in microseconds, using a tick taken from the system clock through a divider that is computed from the clock frequency parameter.

The line is modelled as a pull-down enable (`line_pull`) and a sampled input (`line_in`). An external pull-up is assumed, so the master never drives the wire high. A host starts an operation with a single-cycle command strobe and then waits for the one-cycle `done` pulse. After a bus reset, `presence` holds the outcome. After a read, `rd_data` holds the received byte. Bytes travel least significant bit first. Each bit occupies a fixed slot that is followed by a short released recovery gap.

Top module: `onewire_master`

## Requirements
- R1: Every window is counted in microsecond ticks of CLK_HZ/1e6 clock cycles. The tick restarts when an operation or a bit slot begins, so every pulse the master drives lasts an exact multiple of that cycle count.
- R2: A bus reset pulls the line low for exactly RST_LOW_US (490) microseconds and then releases it.
- R3: After the reset pulse ends, the master watches the line for PRES_WAIT_US (100) microseconds. If the line is never low in that window, the operation ends with `presence` = 0 at the end of the window.
- R4: Once the line is seen low, `presence` becomes 1. The master then waits at most PRES_REL_US (200) microseconds for the line to return high before it completes. A device that holds the line low for longer still yields `presence` = 1, and the operation still completes within that limit.
- R5: A write-0 slot pulls the line low for SLOT_US (80) microseconds. A write-1 slot pulls it low for W1_LOW_US (2) microseconds. Every slot spans SLOT_US microseconds and is followed by at least REC_US (2) microseconds with the line released.
- R6: A read slot pulls the line low for RD_LOW_US (2) microseconds and then releases it. It samples the line RD_SAMPLE_US (9) microseconds after the slot begins, where a low line reads as 0 and a high line as 1. The slot spans SLOT_US microseconds plus the recovery gap.
- R7: Bytes are sent and received least significant bit first. The byte received by a read appears on `rd_data` with the first received bit at bit 0.
- R8: The line is only ever pulled low or released. Out of reset, and whenever no operation is in progress, `line_pull` is 0.
- R9: `cmd_op` codes are 0 = none (ignored), 1 = bus reset, 2 = write `cmd_data`, 3 = read. A command is accepted only when `busy` is 0. Strobes that arrive while `busy` is 1 are ignored. `done` is a one-cycle pulse, and `busy` is already 0 in that cycle.
- R10: `presence` changes only when a bus reset completes, and `rd_data` changes only when a read completes. Both read 0 out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Operation code (0 none, 1 reset, 2 write, 3 read) |
| cmd_data | input | BYTE_BITS | Byte to transmit for a write |
| line_in | input | 1 | Sampled level of the wire |
| line_pull | output | 1 | 1 pulls the wire low, 0 releases it |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| presence | output | 1 | Result of the last bus reset |
| rd_data | output | BYTE_BITS | Byte from the last read |

## Verification
The bench builds the block with CLK_HZ set to 4 MHz, which gives four clocks per microsecond, and keeps every timing window at its default. A full reset with presence takes a few thousand cycles and a byte slot sequence roughly 2,600 cycles, so many operations fit in one run. The short divider still leaves room for the two-flop input synchronizer to settle before each tick-aligned sample. A behavioural device on the line answers presence, holds the line low to signal read zeros, and can hold the line low for too long. Pulse widths and gaps are measured in cycles and compared against whole multiples of four.

// File: rtl/ow_pkg.sv
package ow_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_RESET = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } ow_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RST,
        ST_BYTE
    } ow_top_e;

    typedef enum logic [1:0] {
        SL_W0,
        SL_W1,
        SL_READ
    } ow_slot_e;

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_LOW,
        RS_WAIT,
        RS_REL
    } ow_rs_e;

    function automatic int clks_per_us(input int hz);
        return hz / 1_000_000;
    endfunction

endpackage

// File: rtl/ow_tick_gen.sv
module ow_tick_gen #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = (cnt == LAST);

    // R1: ticks are isolated single-cycle pulses
    a_r1_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/ow_reset_seq.sv
module ow_reset_seq
    import ow_pkg::*;
#(
    parameter int LOW_US  = 490,
    parameter int WAIT_US = 100,
    parameter int REL_US  = 200,
    parameter int UW      = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic tick,
    input  logic line_s,
    output logic pull,
    output logic done,
    output logic presence
);
    ow_rs_e         state;
    logic [UW-1:0]  us;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RS_IDLE;
            us       <= '0;
            pull     <= 1'b0;
            done     <= 1'b0;
            presence <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                RS_IDLE: begin
                    if (start) begin
                        state <= RS_LOW;
                        us    <= '0;
                        pull  <= 1'b1;
                    end
                end
                RS_LOW: begin
                    if (tick) begin
                        if (us == UW'(LOW_US - 1)) begin
                            pull  <= 1'b0;
                            state <= RS_WAIT;
                            us    <= '0;
                        end else begin
                            us <= us + 1'b1;
                        end
                    end
                end
                RS_WAIT: begin
                    if (tick) begin
                        if (!line_s) begin
                            state <= RS_REL;
                            us    <= '0;
                        end else if (us == UW'(WAIT_US - 1)) begin
                            presence <= 1'b0;
                            done     <= 1'b1;
                            state    <= RS_IDLE;
                        end else begin
                            us <= us + 1'b1;
                        end
                    end
                end
                RS_REL: begin
                    if (tick) begin
                        if (line_s || us == UW'(REL_US - 1)) begin
                            presence <= 1'b1;
                            done     <= 1'b1;
                            state    <= RS_IDLE;
                        end else begin
                            us <= us + 1'b1;
                        end
                    end
                end
                default: state <= RS_IDLE;
            endcase
        end
    end

    // R2: the reset pulse only begins on a start request
    a_r2_pull_needs_start: assert property (@(posedge clk) disable iff (rst)
        $rose(pull) |-> $past(start));

    // R3: completion never coincides with the line still being pulled
    a_r3_done_released: assert property (@(posedge clk) disable iff (rst)
        done |-> !pull);

endmodule

// File: rtl/ow_bit_slot.sv
module ow_bit_slot
    import ow_pkg::*;
#(
    parameter int SLOT_US      = 80,
    parameter int W1_LOW_US    = 2,
    parameter int RD_LOW_US    = 2,
    parameter int RD_SAMPLE_US = 9,
    parameter int REC_US       = 2,
    parameter int UW           = 10
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  ow_slot_e kind,
    input  logic     tick,
    input  logic     line_s,
    output logic     pull,
    output logic     done,
    output logic     rbit
);
    localparam logic [UW-1:0] END_US  = UW'(SLOT_US + REC_US);
    localparam logic [UW-1:0] SMP_US  = UW'(RD_SAMPLE_US);

    logic          active;
    logic          is_rd;
    logic [UW-1:0] us;
    logic [UW-1:0] us_nxt;
    logic [UW-1:0] low_len;

    assign us_nxt = us + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            is_rd   <= 1'b0;
            us      <= '0;
            low_len <= '0;
            pull    <= 1'b0;
            done    <= 1'b0;
            rbit    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    pull   <= 1'b1;
                    us     <= '0;
                    is_rd  <= (kind == SL_READ);
                    unique case (kind)
                        SL_W0:   low_len <= UW'(SLOT_US);
                        SL_W1:   low_len <= UW'(W1_LOW_US);
                        default: low_len <= UW'(RD_LOW_US);
                    endcase
                end
            end else if (tick) begin
                us <= us_nxt;
                if (us_nxt == low_len) begin
                    pull <= 1'b0;
                end
                if (is_rd && us_nxt == SMP_US) begin
                    rbit <= line_s;
                end
                if (us_nxt == END_US) begin
                    active <= 1'b0;
                    pull   <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    // R5: a slot ends with the line released (recovery gap)
    a_r5_slot_ends_released: assert property (@(posedge clk) disable iff (rst)
        done |-> !pull);

    // R6: a slot pulse only begins on a start request
    a_r6_pull_needs_start: assert property (@(posedge clk) disable iff (rst)
        $rose(pull) |-> $past(start));

endmodule

// File: rtl/onewire_master.sv
module onewire_master
    import ow_pkg::*;
#(
    parameter int CLK_HZ       = 50_000_000,
    parameter int RST_LOW_US   = 490,
    parameter int PRES_WAIT_US = 100,
    parameter int PRES_REL_US  = 200,
    parameter int SLOT_US      = 80,
    parameter int W1_LOW_US    = 2,
    parameter int RD_LOW_US    = 2,
    parameter int RD_SAMPLE_US = 9,
    parameter int REC_US       = 2,
    parameter int BYTE_BITS    = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_op,
    input  logic [BYTE_BITS-1:0] cmd_data,
    input  logic                 line_in,
    output logic                 line_pull,
    output logic                 busy,
    output logic                 done,
    output logic                 presence,
    output logic [BYTE_BITS-1:0] rd_data
);
    localparam int DIV = clks_per_us(CLK_HZ);
    localparam int UW  = $clog2(RST_LOW_US + PRES_WAIT_US + PRES_REL_US + SLOT_US + REC_US + 1);
    localparam int BW  = $clog2(BYTE_BITS);
    localparam logic [BW-1:0] LAST_BIT = BW'(BYTE_BITS - 1);

    // two-flop synchronizer for the wire level
    logic line_m, line_s;
    always_ff @(posedge clk) begin
        if (rst) begin
            line_m <= 1'b1;
            line_s <= 1'b1;
        end else begin
            line_m <= line_in;
            line_s <= line_m;
        end
    end

    ow_top_e               state;
    ow_op_e                op_in;
    logic                  accept, rst_start, slot_start, next_slot, last_bit;
    logic                  tick;
    logic                  rs_pull, rs_done;
    logic                  sl_pull, sl_done, sl_rbit;
    ow_slot_e              sl_kind;
    logic [BYTE_BITS-1:0]  shreg;
    logic [BYTE_BITS-1:0]  shifted;
    logic [BW-1:0]         bit_idx;
    logic                  is_read;

    assign op_in      = ow_op_e'(cmd_op);
    assign accept     = (state == ST_IDLE) && cmd_valid && (op_in != OP_NONE);
    assign rst_start  = accept && (op_in == OP_RESET);
    assign last_bit   = (bit_idx == LAST_BIT);
    assign next_slot  = (state == ST_BYTE) && sl_done && !last_bit;
    assign slot_start = (accept && (op_in == OP_WRITE || op_in == OP_READ)) || next_slot;
    assign shifted    = {(is_read ? sl_rbit : 1'b0), shreg[BYTE_BITS-1:1]};

    always_comb begin
        if (accept) begin
            if (op_in == OP_READ)  sl_kind = SL_READ;
            else if (cmd_data[0])  sl_kind = SL_W1;
            else                   sl_kind = SL_W0;
        end else begin
            if (is_read)           sl_kind = SL_READ;
            else if (shreg[1])     sl_kind = SL_W1;
            else                   sl_kind = SL_W0;
        end
    end

    ow_tick_gen #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .clr  (rst_start || slot_start),
        .tick (tick)
    );

    ow_reset_seq #(
        .LOW_US  (RST_LOW_US),
        .WAIT_US (PRES_WAIT_US),
        .REL_US  (PRES_REL_US),
        .UW      (UW)
    ) u_rst (
        .clk      (clk),
        .rst      (rst),
        .start    (rst_start),
        .tick     (tick),
        .line_s   (line_s),
        .pull     (rs_pull),
        .done     (rs_done),
        .presence (presence)
    );

    ow_bit_slot #(
        .SLOT_US      (SLOT_US),
        .W1_LOW_US    (W1_LOW_US),
        .RD_LOW_US    (RD_LOW_US),
        .RD_SAMPLE_US (RD_SAMPLE_US),
        .REC_US       (REC_US),
        .UW           (UW)
    ) u_slot (
        .clk    (clk),
        .rst    (rst),
        .start  (slot_start),
        .kind   (sl_kind),
        .tick   (tick),
        .line_s (line_s),
        .pull   (sl_pull),
        .done   (sl_done),
        .rbit   (sl_rbit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            shreg   <= '0;
            bit_idx <= '0;
            is_read <= 1'b0;
            done    <= 1'b0;
            rd_data <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (op_in == OP_RESET) begin
                            state <= ST_RST;
                        end else begin
                            state   <= ST_BYTE;
                            shreg   <= cmd_data;
                            bit_idx <= '0;
                            is_read <= (op_in == OP_READ);
                        end
                    end
                end
                ST_RST: begin
                    if (rs_done) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                ST_BYTE: begin
                    if (sl_done) begin
                        shreg <= shifted;
                        if (last_bit) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                            if (is_read) rd_data <= shifted;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state != ST_IDLE);
    assign line_pull = rs_pull | sl_pull;

    // R8: the wire is released whenever no operation runs
    a_r8_idle_released: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !line_pull);

    // R9: done lasts a single cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: busy has already dropped when done is seen
    a_r9_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

// File: tb/sim_onewire_master.sv
module sim_onewire_master;
    localparam int CLK_HZ = 4_000_000;
    localparam int D      = 4;
    localparam int NV     = 10;

    // vector fields: op[26:25] data[24:17] dev[16:9] pres[8] exp[7:0]
    localparam logic [26:0] VECS [NV] = '{
        {2'd1, 8'h00, 8'h00, 1'b1, 8'h01},
        {2'd2, 8'hA5, 8'h00, 1'b0, 8'hA5},
        {2'd2, 8'h00, 8'h00, 1'b0, 8'h00},
        {2'd2, 8'hFF, 8'h00, 1'b0, 8'hFF},
        {2'd3, 8'h00, 8'h3C, 1'b0, 8'h3C},
        {2'd3, 8'h00, 8'h00, 1'b0, 8'h00},
        {2'd3, 8'h00, 8'hFF, 1'b0, 8'hFF},
        {2'd1, 8'h00, 8'h00, 1'b0, 8'h00},
        {2'd2, 8'h01, 8'h00, 1'b0, 8'h01},
        {2'd3, 8'h00, 8'h80, 1'b0, 8'h80}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [7:0] cmd_data = 8'h00;
    logic       line_in;
    logic       line_pull, busy, done, presence;
    logic [7:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;

    // bench-side device and monitor state
    int         mode = 0;
    logic [7:0] dev_byte = 8'h00;
    logic       pres_en = 1'b0;
    int         pres_hold = 120 * D;
    logic       dev_pull = 1'b0;
    logic       prev_pull = 1'b0;
    int         low_len = 0, high_len = 0;
    int         last_low = 0, w0_len = 0, w1_len = 0;
    int         min_gap = 1_000_000;
    int         pres_dly = 0, hold = 0;
    logic [7:0] cap = 8'h00;
    int         cap_n = 0, rd_i = 0;
    int         n_done = 0;

    always #5 clk = ~clk;

    assign line_in = ~(line_pull | dev_pull);

    onewire_master #(.CLK_HZ(CLK_HZ)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .line_in(line_in), .line_pull(line_pull),
        .busy(busy), .done(done), .presence(presence), .rd_data(rd_data)
    );

    always @(posedge clk) begin
        prev_pull <= line_pull;
        if (done) n_done <= n_done + 1;
        if (cmd_valid && !busy) begin
            cap   <= 8'h00;
            cap_n <= 0;
            rd_i  <= 0;
        end
        if (line_pull) low_len  <= low_len + 1;
        else           high_len <= high_len + 1;
        if (hold > 0) begin
            hold <= hold - 1;
            if (hold == 1) dev_pull <= 1'b0;
        end
        if (pres_dly > 0) begin
            pres_dly <= pres_dly - 1;
            if (pres_dly == 1) begin
                dev_pull <= 1'b1;
                hold     <= pres_hold;
            end
        end
        if (!line_pull && prev_pull) begin
            last_low <= low_len;
            low_len  <= 0;
            if (mode == 1 && pres_en) pres_dly <= 20 * D;
            if (mode == 2) begin
                cap[cap_n] <= (low_len < 10 * D);
                cap_n      <= cap_n + 1;
                if (low_len < 10 * D) w1_len <= low_len;
                else                  w0_len <= low_len;
            end
        end
        if (line_pull && !prev_pull) begin
            if (mode >= 2 && high_len < min_gap) min_gap <= high_len;
            high_len <= 0;
            if (mode == 3) begin
                rd_i <= rd_i + 1;
                if (!dev_byte[rd_i]) begin
                    dev_pull <= 1'b1;
                    hold     <= 30 * D;
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [7:0] data);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_data  = data;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = 2'd0;
    endtask

    task automatic wait_done(output int cycles);
        cycles = 0;
        while (!done && cycles < 20000) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int cyc;
        int dn;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8 idle line", {31'd0, line_pull}, 32'd0);
        check("R9 busy after reset", {31'd0, busy}, 32'd0);
        check("R10 presence after reset", {31'd0, presence}, 32'd0);
        check("R10 rd_data after reset", {24'd0, rd_data}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            mode     = int'(VECS[i][26:25]);
            dev_byte = VECS[i][16:9];
            pres_en  = VECS[i][8];
            pres_hold = 120 * D;
            issue(VECS[i][26:25], VECS[i][24:17]);
            wait_done(cyc);
            @(negedge clk);
            if (mode == 1) begin
                check("R3/R4 presence", {31'd0, presence}, {24'd0, VECS[i][7:0]});
                check("R1 R2 reset low width", last_low, 490 * D);
            end else if (mode == 2) begin
                check("R7 written byte", {24'd0, cap}, {24'd0, VECS[i][7:0]});
                if (VECS[i][24:17] == 8'hA5) begin
                    check("R5 write-1 low", w1_len, 2 * D);
                    check("R5 write-0 low", w0_len, 80 * D);
                end
            end else begin
                check("R6 R7 read byte", {24'd0, rd_data}, {24'd0, VECS[i][7:0]});
            end
            repeat (40 * D) @(negedge clk);
        end
        check("R5 recovery gap", {31'd0, (min_gap >= 2 * D)}, 32'd1);

        // R9: op code 0 is ignored
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd0;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 op none ignored", {30'd0, busy, line_pull}, 32'd0);

        // R9/R10: a strobe during a write is ignored, results hold
        mode = 2;
        dn = n_done;
        issue(2'd2, 8'h5A);
        repeat (100) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd3;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'd0;
        wait_done(cyc);
        repeat (10 * D) @(negedge clk);
        check("R9 busy strobe ignored", {24'd0, cap}, 32'h5A);
        check("R9 single done", n_done - dn, 1);
        check("R9 idle after op", {31'd0, busy}, 32'd0);
        check("R10 rd_data held", {24'd0, rd_data}, 32'h80);
        check("R10 presence held", {31'd0, presence}, 32'd0);

        // R3: no-presence completion time
        mode = 1; pres_en = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd1;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'd0;
        cyc = 1;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        check("R3 no-presence timing", {31'd0, (cyc >= 590 * D && cyc <= 590 * D + 3)}, 32'd1);
        check("R3 no presence", {31'd0, presence}, 32'd0);
        repeat (10 * D) @(negedge clk);

        // R4: device holds the line too long
        mode = 1; pres_en = 1'b1; pres_hold = 400 * D;
        issue(2'd1, 8'h00);
        wait_done(cyc);
        check("R4 stuck presence", {31'd0, presence}, 32'd1);
        check("R4 release timeout", {31'd0, (cyc <= 790 * D + 2 && cyc >= 690 * D)}, 32'd1);
        while (dev_pull) @(negedge clk);
        pres_hold = 120 * D;
        repeat (10 * D) @(negedge clk);
        check("R8 released at end", {31'd0, line_pull}, 32'd0);

        finish_run();
    end

endmodule